// File: doc/BRIEF.md
# Chained Configuration Frame Loader

This block sits behind the header decoder of a daisy-chained LED driver and extracts the device's own configuration from a configuration payload. The payload carries one word group per device. The group for the device farthest down the chain arrives first, and the group for the device nearest the controller arrives last. For this reason every device skips and forwards the first N-1 groups and captures only the final group it sees.

Once the header is accepted, the decoder pulses `start` and supplies the chain length minus one and the word format. Two formats exist. The wide format has 16-bit words and 48 bits per device. The narrow format has 10-bit words and 30 bits per device. Each group holds two copies of the 10-bit main configuration and a 3-bit auxiliary value. The main register is written only when the two copies agree. A write strobe, and optionally a PWM counter-reset strobe, marks the update. A payload that is cut short, or that is abandoned through `abort`, changes nothing.

The controller is a four-state machine:
- IDLE waits for `start`.
- SKIP forwards foreign groups.
- CAPTURE shifts in the own group.
- COMMIT compares and writes.

The transitions are:
- IDLE to SKIP on `start` with a chain length above one.
- IDLE to CAPTURE on `start` with a chain of one.
- SKIP to CAPTURE at the end of the next-to-last group.
- CAPTURE to COMMIT at the last bit of the own group.
- COMMIT to IDLE unconditionally.
- Any state to IDLE on `abort`.
- Any state to SKIP or CAPTURE on a new `start`.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset, `main_cfg` equals 10'h37F and `aux_cfg` equals 3'b111. The main value's fields are:
  - [9:8] clock divider, reset value 11.
  - [7] dot-correction bypass, reset value 0.
  - [6:5] reserved, reset value 11.
  - [4] counter reset on write, reset value 1.
  - [3] auto sync, reset value 1.
  - [2:1] reserved, reset value 11.
  - [0] header parity enable, reset value 1.

  `cfg_wr`, `cnt_reset` and `fwd_valid` are low after reset.
- R2: In the wide format a group is 48 bits, sent MSB first. Bits [41:32] hold the first main copy, bits [25:16] hold the second copy and bits [2:0] hold the auxiliary value. All other bits are ignored.
- R3: In the narrow format a group is 30 bits, sent MSB first. Bits [29:20] hold the first copy, bits [19:10] hold the second copy and bits [2:0] hold the auxiliary value. Bits [9:3] are ignored.
- R4: After `start` with `chain_m1` = N-1, the first (N-1) groups are not captured. Each of their accepted bits appears on `fwd_bit` with `fwd_valid` high one cycle later. Only the final group is captured.
- R5: If the two copies match, `main_cfg` takes the copy and `cfg_wr` is high for exactly one cycle. That cycle is the second cycle after the clock edge that accepts the last bit. `main_cfg` never changes without `cfg_wr`.
- R6: If the copies differ, `main_cfg` keeps its value and no `cfg_wr` is issued.
- R7: `aux_cfg` is loaded at the end of every complete own group, whether or not the copies match.
- R8: `abort` before the last bit leaves both registers unchanged. Later bits are ignored until the next `start`.
- R9: `cnt_reset` pulses together with `cfg_wr` exactly when bit [4] of the newly written main value is 1.
- R10: Bits offered while idle are neither captured nor forwarded.
- R11: A `start` in the middle of a frame discards the partial frame and begins a new one.
- R12: Cycles with `bit_valid` low pause reception without affecting the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Header accepted; begin payload |
| fmt_wide | input | 1 | 1 = 48-bit groups, 0 = 30-bit groups (sampled with start) |
| chain_m1 | input | CHAIN_W | Devices in chain minus one (sampled with start) |
| abort | input | 1 | Abandon the current payload |
| bit_valid | input | 1 | A payload bit is offered this cycle |
| bit_in | input | 1 | Payload bit value |
| fwd_valid | output | 1 | Forwarded bit valid |
| fwd_bit | output | 1 | Forwarded bit for downstream devices |
| main_cfg | output | 10 | Committed main configuration |
| aux_cfg | output | 3 | Committed auxiliary configuration |
| cfg_wr | output | 1 | One-cycle main-register write strobe |
| cnt_reset | output | 1 | PWM counter reset strobe |

## Verification
The bench builds the block with the default CHAIN_W of 10 and chains of one to four devices. This covers both the direct IDLE-to-CAPTURE path and the SKIP path in both formats, including multiple skipped groups. It checks every forwarded bit against the filler pattern and drives gaps in `bit_valid`. The frames include mismatched copies, aborts during SKIP and during CAPTURE, a mid-frame restart, and main values with the counter-reset bit both set and clear.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int MAIN_W      = 10;
    localparam int AUX_W       = 3;
    localparam int WIDE_BITS   = 48;
    localparam int NARROW_BITS = 30;
    localparam int IDX_W       = $clog2(WIDE_BITS);

    // field positions inside one device group
    localparam int WIDE_A_LSB   = 32;
    localparam int WIDE_B_LSB   = 16;
    localparam int NARROW_A_LSB = 20;
    localparam int NARROW_B_LSB = 10;

    localparam int CNT_RST_BIT = 4;

    localparam logic [MAIN_W-1:0] MAIN_RST = 10'h37F;
    localparam logic [AUX_W-1:0]  AUX_RST  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SKIP,
        ST_CAPTURE,
        ST_COMMIT
    } ld_state_e;

    typedef struct packed {
        logic [MAIN_W-1:0] copy_a;
        logic [MAIN_W-1:0] copy_b;
        logic [AUX_W-1:0]  aux;
    } cfg_fields_t;
endpackage

// File: rtl/cfl_seq_count.sv
module cfl_seq_count
    import cfl_pkg::*;
#(
    parameter int CHAIN_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               load_wide,
    input  logic [CHAIN_W-1:0] load_groups,
    input  logic               step,
    output logic               group_end,
    output logic               one_left,
    output logic               wide_q
);
    localparam logic [IDX_W-1:0] WIDE_TOP   = IDX_W'(WIDE_BITS - 1);
    localparam logic [IDX_W-1:0] NARROW_TOP = IDX_W'(NARROW_BITS - 1);

    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   top_idx;
    logic [CHAIN_W-1:0] grp_left;

    assign top_idx   = wide_q ? WIDE_TOP : NARROW_TOP;
    assign group_end = (bit_idx == top_idx);
    assign one_left  = (grp_left == CHAIN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            grp_left <= '0;
            wide_q   <= 1'b0;
        end else if (load) begin
            bit_idx  <= '0;
            grp_left <= load_groups;
            wide_q   <= load_wide;
        end else if (step) begin
            if (group_end) begin
                bit_idx <= '0;
                if (grp_left != '0) begin
                    grp_left <= grp_left - CHAIN_W'(1);
                end
            end else begin
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= top_idx);

    // R4
    grp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && group_end && grp_left != '0)
            |=> grp_left == $past(grp_left) - CHAIN_W'(1));
endmodule

// File: rtl/cfl_capture.sv
module cfl_capture
    import cfl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        shift,
    input  logic        din,
    input  logic        wide,
    output cfg_fields_t fields
);
    logic [WIDE_BITS-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (clear) begin
            shreg <= '0;
        end else if (shift) begin
            shreg <= {shreg[WIDE_BITS-2:0], din};
        end
    end

    always_comb begin
        if (wide) begin
            fields.copy_a = shreg[WIDE_A_LSB +: MAIN_W];
            fields.copy_b = shreg[WIDE_B_LSB +: MAIN_W];
        end else begin
            fields.copy_a = shreg[NARROW_A_LSB +: MAIN_W];
            fields.copy_b = shreg[NARROW_B_LSB +: MAIN_W];
        end
        fields.aux = shreg[AUX_W-1:0];
    end

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift) |=> $stable(shreg));
endmodule

// File: rtl/cfl_commit.sv
module cfl_commit
    import cfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cfg_fields_t       fields,
    output logic [MAIN_W-1:0] main_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic              wr_pulse,
    output logic              crst_pulse
);
    logic copies_equal;

    assign copies_equal = (fields.copy_a == fields.copy_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q     <= MAIN_RST;
            aux_q      <= AUX_RST;
            wr_pulse   <= 1'b0;
            crst_pulse <= 1'b0;
        end else begin
            wr_pulse   <= 1'b0;
            crst_pulse <= 1'b0;
            if (commit) begin
                aux_q <= fields.aux;
                if (copies_equal) begin
                    main_q     <= fields.copy_a;
                    wr_pulse   <= 1'b1;
                    crst_pulse <= fields.copy_a[CNT_RST_BIT];
                end
            end
        end
    end

    // R5
    main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |-> $stable(main_q));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R9
    crst_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst_pulse |-> (wr_pulse && main_q[CNT_RST_BIT]));

    // R6
    mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !copies_equal) |=> !wr_pulse);
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfl_pkg::*;
#(
    parameter int CHAIN_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               fmt_wide,
    input  logic [CHAIN_W-1:0] chain_m1,
    input  logic               abort,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic               fwd_valid,
    output logic               fwd_bit,
    output logic [MAIN_W-1:0]  main_cfg,
    output logic [AUX_W-1:0]   aux_cfg,
    output logic               cfg_wr,
    output logic               cnt_reset
);
    ld_state_e   state_q, state_d;
    logic        group_end, one_left, wide_q;
    logic        accept, step, shift, commit;
    cfg_fields_t fields;

    // a bit counts only when no start or abort overrides the cycle
    assign accept = bit_valid && !start && !abort;
    assign step   = accept && (state_q == ST_SKIP || state_q == ST_CAPTURE);
    assign shift  = accept && (state_q == ST_CAPTURE);
    assign commit = (state_q == ST_COMMIT);

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (chain_m1 == '0) ? ST_CAPTURE : ST_SKIP;
        end else if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SKIP: begin
                    if (bit_valid && group_end && one_left) begin
                        state_d = ST_CAPTURE;
                    end
                end
                ST_CAPTURE: begin
                    if (bit_valid && group_end) begin
                        state_d = ST_COMMIT;
                    end
                end
                ST_COMMIT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_bit   <= 1'b0;
        end else begin
            fwd_valid <= accept && (state_q == ST_SKIP);
            fwd_bit   <= bit_in;
        end
    end

    cfl_seq_count #(.CHAIN_W(CHAIN_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .load_wide   (fmt_wide),
        .load_groups (chain_m1),
        .step        (step),
        .group_end   (group_end),
        .one_left    (one_left),
        .wide_q      (wide_q)
    );

    cfl_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .shift  (shift),
        .din    (bit_in),
        .wide   (wide_q),
        .fields (fields)
    );

    cfl_commit u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .fields     (fields),
        .main_q     (main_cfg),
        .aux_q      (aux_cfg),
        .wr_pulse   (cfg_wr),
        .crst_pulse (cnt_reset)
    );

    // R4
    fwd_only_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(state_q == ST_SKIP));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start) |=> state_q == ST_IDLE);

    // R5
    commit_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !start && !abort) |=> state_q == ST_IDLE);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !fwd_valid));
endmodule

// File: tb/tb_cfg_chain_loader.sv
module tb_cfg_chain_loader;
    localparam int CHAIN_W = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               fmt_wide = 1'b0;
    logic [CHAIN_W-1:0] chain_m1 = '0;
    logic               abort = 1'b0;
    logic               bit_valid = 1'b0;
    logic               bit_in = 1'b0;
    logic               fwd_valid, fwd_bit, cfg_wr, cnt_reset;
    logic [9:0]         main_cfg;
    logic [2:0]         aux_cfg;

    int n_chk = 0;
    int n_fail = 0;
    int fwd_cnt = 0;
    logic [9:0]  exp_main = 10'h37F;
    logic [2:0]  exp_aux = 3'b111;
    logic [10:0] exp_q[$];

    always #4 clk = ~clk;

    cfg_chain_loader #(.CHAIN_W(CHAIN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_wide(fmt_wide),
        .chain_m1(chain_m1), .abort(abort), .bit_valid(bit_valid),
        .bit_in(bit_in), .fwd_valid(fwd_valid), .fwd_bit(fwd_bit),
        .main_cfg(main_cfg), .aux_cfg(aux_cfg), .cfg_wr(cfg_wr),
        .cnt_reset(cnt_reset)
    );

    function automatic logic filler(input int i);
        return ((i * 5 + 3) % 7) < 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (fwd_valid) begin
                chk(fwd_bit == filler(fwd_cnt), "R4 forwarded bit", int'(fwd_bit), int'(filler(fwd_cnt)));
                fwd_cnt++;
            end
            if (cfg_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected cfg_wr", 1, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk(main_cfg == e[10:1], "R5 written main value", int'(main_cfg), int'(e[10:1]));
                    chk(cnt_reset == e[0], "R9 cnt_reset with write", int'(cnt_reset), int'(e[0]));
                end
            end else if (cnt_reset) begin
                chk(1'b0, "R9 cnt_reset without write", 1, 0);
            end
        end
    end

    task automatic send_frame(input bit wide, input int ndev, input logic [9:0] ca,
                              input logic [9:0] cb, input logic [2:0] ax, input int cut,
                              input bit do_abort, input int gap, input bit settle);
        int gb;
        int total;
        int nskip;
        logic [47:0] own;
        gb    = wide ? 48 : 30;
        total = ndev * gb;
        nskip = (ndev - 1) * gb;
        own   = wide ? {6'h2A, ca, 6'h15, cb, 13'h1ABC, ax}
                     : {18'h0, ca, cb, 7'h55, ax};
        fwd_cnt = 0;
        @(negedge clk);
        start    = 1'b1;
        fmt_wide = wide;
        chain_m1 = CHAIN_W'(ndev - 1);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total && i < cut; i++) begin
            if (gap != 0 && (i % gap) == gap - 1) begin
                bit_valid = 1'b0;
                bit_in    = 1'b1;
                @(negedge clk);
            end
            bit_valid = 1'b1;
            bit_in    = (i < nskip) ? filler(i) : own[gb - 1 - (i - nskip)];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        if (do_abort) begin
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end
        @(negedge clk);
        if (cut >= total) begin
            exp_aux = ax;
            if (ca == cb) begin
                exp_main = ca;
                exp_q.push_back({ca, ca[4]});
            end
        end
        if (settle) begin
            repeat (4) @(negedge clk);
            chk(main_cfg == exp_main, "R5/R6/R8 main register", int'(main_cfg), int'(exp_main));
            chk(aux_cfg == exp_aux, "R7/R8 aux register", int'(aux_cfg), int'(exp_aux));
            chk(exp_q.size() == 0, "R5 pending writes", exp_q.size(), 0);
            if (cut >= total) begin
                chk(fwd_cnt == nskip, "R4 forwarded count", fwd_cnt, nskip);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(main_cfg == 10'h37F, "R1 main reset", int'(main_cfg), 'h37F);
        chk(aux_cfg == 3'b111, "R1 aux reset", int'(aux_cfg), 7);
        chk(!cfg_wr && !cnt_reset, "R1 strobes low", int'(cfg_wr), 0);
        chk(!fwd_valid, "R1 forward idle", int'(fwd_valid), 0);

        // R2 wide, single device, counter-reset bit clear
        send_frame(1'b1, 1, 10'h2C5, 10'h2C5, 3'b010, 1000, 1'b0, 0, 1'b1);
        // R3 narrow, single device, counter-reset bit set
        send_frame(1'b0, 1, 10'h1B3, 10'h1B3, 3'b101, 1000, 1'b0, 0, 1'b1);
        // R4 wide, three devices
        send_frame(1'b1, 3, 10'h0F0, 10'h0F0, 3'b011, 1000, 1'b0, 0, 1'b1);
        // R12 narrow, four devices, gaps in bit_valid
        send_frame(1'b0, 4, 10'h30A, 10'h30A, 3'b110, 1000, 1'b0, 5, 1'b1);
        // R6 R7 copies differ
        send_frame(1'b1, 2, 10'h155, 10'h154, 3'b001, 1000, 1'b0, 0, 1'b1);
        // R8 abort inside own group
        send_frame(1'b0, 2, 10'h011, 10'h011, 3'b000, 45, 1'b1, 0, 1'b1);
        // R8 abort while skipping
        send_frame(1'b1, 3, 10'h022, 10'h022, 3'b000, 60, 1'b1, 0, 1'b1);

        // R10 R8 bits offered while idle
        fwd_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            bit_valid = 1'b1;
            bit_in    = i[0];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(fwd_cnt == 0, "R10 no forwarding when idle", fwd_cnt, 0);
        chk(main_cfg == exp_main, "R10 main unchanged", int'(main_cfg), int'(exp_main));
        chk(aux_cfg == exp_aux, "R10 aux unchanged", int'(aux_cfg), int'(exp_aux));

        // R11 restart mid-frame
        send_frame(1'b1, 2, 10'h3C3, 10'h3C3, 3'b000, 70, 1'b0, 0, 1'b0);
        send_frame(1'b0, 1, 10'h2AA, 10'h2AA, 3'b100, 1000, 1'b0, 0, 1'b1);
        chk(main_cfg == 10'h2AA, "R11 restart result", int'(main_cfg), 'h2AA);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule